// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is a register-bus slave that holds a bank of configuration words, some of them guarded against stray writes. Software reaches every word through one synchronous bus: a shared address, write data with a write strobe, and a read strobe. Read data is registered and appears one cycle after the read strobe.

Two guard schemes are available. In the first, a protected word has its own lock register. Writing the correct key to that lock register opens the word for a short window of clock cycles. After that window the word closes again without any further action. In the second, a set of words is opened only while two kick registers both hold their own keys. Clearing either kick register closes the whole set. Words that neither scheme covers accept every write. A write to a closed word is dropped without any response. Reads are never blocked.

The key values, the addresses of the lock and kick registers, which words each scheme guards, and the length of the relock window are all parameters.

Top module: `kp_unlock_regs`

## Requirements
- R1: After a synchronous active-high reset, every configuration word reads 0, every lock register reads 0 and both kick registers read 0.
- R2: Configuration words covered by neither scheme (indices 6 and 7 by default) take every write.
- R3: A write to a lock-guarded word while its lock is closed is dropped and the word keeps its value. An open kick pair does not open a lock-guarded word.
- R4: Writing the slot's key to lock register i opens word LOCK_TGT[i]. A write to that word is accepted on the 1st through RELOCK_WIN-th clock edges after the key-write edge (4 by default). From the next edge on it is dropped.
- R5: Writing any other non-zero value to a lock register leaves it closed, or closes it if it was open.
- R6: Writing 0 to a lock register closes it at once, so a write on the following edge is dropped.
- R7: Lock register i (address LOCK_BASE+i) reads 1 in bit 0 while open and 0 while closed, with the upper bits 0. A guarded word reads its stored value whether or not it is open.
- R8: Kick-guarded words (indices 4 and 5 by default) accept writes only while kick register 0 (KICK_BASE) holds KICK_KEY0 and kick register 1 (KICK_BASE+1) holds KICK_KEY1. Each kick register reads 1 in bit 0 while it holds its key.
- R9: Writing 0 (or any non-key value) to either kick register removes write access to all kick-guarded words on the next edge.
- R10: Read data is registered. rd_data shows the value from before any write on the same edge. An unmapped address reads 0, and writes to it change nothing.
- R11: Each lock slot decodes only its own key. Another slot's key written to a lock register leaves that lock closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address shared by read and write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data, valid the cycle after rd_en |

## Verification
The bench attacks the edges of the relock window. It writes a guarded word exactly RELOCK_WIN edges after the key, and then one edge later. A timer that is off by one either drops the first write or keeps the second. It then probes key confusion. A wrong key written over an open lock must close it. A neighbour's key must not open a slot. An open kick pair must not leak into lock-guarded words. A design that ANDs the wrong enables lets those writes through. Finally, it checks that a single kick key, or a kick cleared after opening, blocks the kick set, and that a read and write to the same word on one edge returns the old value.

// File: rtl/kp_pkg.sv
package kp_pkg;
  // which part of the map an address falls in
  typedef enum logic [1:0] {
    SPACE_NONE = 2'd0,
    SPACE_CFG  = 2'd1,
    SPACE_LOCK = 2'd2,
    SPACE_KICK = 2'd3
  } space_e;
endpackage

// File: rtl/kp_lock_slot.sv
module kp_lock_slot #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'h5A5A_0001,
  parameter int unsigned WIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              open_o
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (key_wr) begin
      cnt <= (wr_data == KEY) ? CNT_W'(WIN) : '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign open_o = (cnt != '0);

  // R4
  key_open_chk: assert property (@(posedge clk) disable iff (rst)
    key_wr && (wr_data == KEY) |=> open_o);
  // R6
  zero_relock_chk: assert property (@(posedge clk) disable iff (rst)
    key_wr && (wr_data == '0) |=> !open_o);
  // R5
  stay_shut_chk: assert property (@(posedge clk) disable iff (rst)
    !open_o && !key_wr |=> !open_o);
  // R4
  window_close_chk: assert property (@(posedge clk) disable iff (rst)
    open_o && !key_wr && (cnt == CNT_W'(1)) |=> !open_o);
endmodule

// File: rtl/kp_kick_pair.sv
module kp_kick_pair #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY0 = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1 = 32'h95A4_F1E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr0,
  input  logic              wr1,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ok0,
  output logic              ok1,
  output logic              open_o
);
  logic [DATA_W-1:0] kick0_q, kick1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kick0_q <= '0;
      kick1_q <= '0;
    end else begin
      if (wr0) kick0_q <= wr_data;
      if (wr1) kick1_q <= wr_data;
    end
  end

  assign ok0    = (kick0_q == KEY0);
  assign ok1    = (kick1_q == KEY1);
  assign open_o = ok0 && ok1;

  // R9
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr0 || wr1) && (wr_data == '0) |=> !open_o);
  // R8
  half_key_chk: assert property (@(posedge clk) disable iff (rst)
    wr0 && (wr_data == KEY0) && !ok1 && !wr1 |=> !open_o);
endmodule

// File: rtl/kp_cfg_bank.sv
module kp_cfg_bank #(
  parameter int unsigned N_CFG  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (N_CFG > 1) ? $clog2(N_CFG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [N_CFG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N_CFG; j++) mem[j] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

  for (genvar j = 0; j < N_CFG; j++) begin : g_hold
    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(we && (idx == IDX_W'(j))) |=> $stable(mem[j]));
  end
endmodule

// File: rtl/kp_unlock_regs.sv
module kp_unlock_regs
  import kp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned N_CFG      = 8,
  parameter int unsigned N_LOCK     = 4,
  parameter int unsigned RELOCK_WIN = 4,
  parameter logic [ADDR_W-1:0] LOCK_BASE = 8'h10,
  parameter logic [ADDR_W-1:0] KICK_BASE = 8'h18,
  parameter logic [N_LOCK*8-1:0] LOCK_TGT = {8'd3, 8'd2, 8'd1, 8'd0},
  parameter logic [N_LOCK*DATA_W-1:0] LOCK_KEY =
    {32'h5A5A_0004, 32'h5A5A_0003, 32'h5A5A_0002, 32'h5A5A_0001},
  parameter logic [DATA_W-1:0] KICK_KEY0 = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KICK_KEY1 = 32'h95A4_F1E0,
  parameter logic [N_CFG-1:0]  KICK_MASK = 8'b0011_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned CIDX_W = (N_CFG > 1) ? $clog2(N_CFG) : 1;
  localparam int unsigned LIDX_W = (N_LOCK > 1) ? $clog2(N_LOCK) : 1;

  space_e             space;
  logic [N_LOCK-1:0]  slot_open;
  logic [N_LOCK-1:0]  slot_wr;
  logic               kick_ok0, kick_ok1, kick_open;
  logic [N_CFG-1:0]   slot_guard, slot_ok, may_write;
  logic               cfg_we;
  logic [DATA_W-1:0]  cfg_rd;
  logic [DATA_W-1:0]  rd_mux;

  // address decode
  always_comb begin
    space = SPACE_NONE;
    if (addr < ADDR_W'(N_CFG))
      space = SPACE_CFG;
    else if (addr >= LOCK_BASE && addr < LOCK_BASE + ADDR_W'(N_LOCK))
      space = SPACE_LOCK;
    else if (addr == KICK_BASE || addr == KICK_BASE + 1'b1)
      space = SPACE_KICK;
  end

  for (genvar i = 0; i < N_LOCK; i++) begin : g_slot
    assign slot_wr[i] = wr_en && (addr == LOCK_BASE + ADDR_W'(i));
    kp_lock_slot #(
      .DATA_W (DATA_W),
      .KEY    (LOCK_KEY[i*DATA_W +: DATA_W]),
      .WIN    (RELOCK_WIN)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .key_wr  (slot_wr[i]),
      .wr_data (wr_data),
      .open_o  (slot_open[i])
    );
  end

  kp_kick_pair #(
    .DATA_W (DATA_W),
    .KEY0   (KICK_KEY0),
    .KEY1   (KICK_KEY1)
  ) u_kick (
    .clk     (clk),
    .rst     (rst),
    .wr0     (wr_en && (addr == KICK_BASE)),
    .wr1     (wr_en && (addr == KICK_BASE + 1'b1)),
    .wr_data (wr_data),
    .ok0     (kick_ok0),
    .ok1     (kick_ok1),
    .open_o  (kick_open)
  );

  // per-word write permission: lock slots win over the kick set
  always_comb begin
    for (int j = 0; j < N_CFG; j++) begin
      slot_guard[j] = 1'b0;
      slot_ok[j]    = 1'b0;
      for (int i = 0; i < N_LOCK; i++) begin
        if (int'(LOCK_TGT[i*8 +: 8]) == j) begin
          slot_guard[j] = 1'b1;
          slot_ok[j]    = slot_ok[j] | slot_open[i];
        end
      end
      if (slot_guard[j])     may_write[j] = slot_ok[j];
      else if (KICK_MASK[j]) may_write[j] = kick_open;
      else                   may_write[j] = 1'b1;
    end
  end

  assign cfg_we = wr_en && (space == SPACE_CFG) && may_write[addr[CIDX_W-1:0]];

  kp_cfg_bank #(
    .N_CFG  (N_CFG),
    .DATA_W (DATA_W)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .idx   (addr[CIDX_W-1:0]),
    .wdata (wr_data),
    .rdata (cfg_rd)
  );

  always_comb begin
    rd_mux = '0;
    unique case (space)
      SPACE_CFG:  rd_mux = cfg_rd;
      SPACE_LOCK: rd_mux = DATA_W'(slot_open[addr[LIDX_W-1:0]]);
      SPACE_KICK: rd_mux = DATA_W'((addr == KICK_BASE) ? kick_ok0 : kick_ok1);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R3
  locked_drop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && (addr == ADDR_W'(LOCK_TGT[7:0])) && (slot_open == '0) |-> !cfg_we);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tb_kp_unlock_regs.sv
`timescale 1ns/1ps
module tb_kp_unlock_regs;
  localparam int WIN = 4;
  localparam logic [31:0] K0 = 32'h83E7_0B13;
  localparam logic [31:0] K1 = 32'h95A4_F1E0;

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  kp_unlock_regs dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  int checks = 0, bad = 0;
  bit finished = 0;

  // behavioural reference model
  logic [31:0] m_cfg [8];
  int          m_tmr [4];
  logic [31:0] m_k0, m_k1;
  logic [31:0] exp_rd;
  bit          pend = 0;
  string       cur_tag = "R1", pend_tag = "R1";

  function automatic logic [31:0] slot_key(int i);
    return 32'h5A5A_0001 + i;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    if (a < 8) return m_cfg[a];
    if (a >= 8'h10 && a < 8'h14) return (m_tmr[a - 8'h10] > 0) ? 32'd1 : 32'd0;
    if (a == 8'h18) return (m_k0 == K0) ? 32'd1 : 32'd0;
    if (a == 8'h19) return (m_k1 == K1) ? 32'd1 : 32'd0;
    return 32'd0;
  endfunction

  function automatic bit model_may(int w);
    if (w < 4) return m_tmr[w] > 0;        // slot i guards word i
    if (w == 4 || w == 5) return (m_k0 == K0) && (m_k1 == K1);
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < 8; j++) m_cfg[j] = '0;
      for (int i = 0; i < 4; i++) m_tmr[i] = 0;
      m_k0 = '0; m_k1 = '0; pend = 0;
    end else begin
      pend = rd_en;
      if (rd_en) begin exp_rd = model_read(addr); pend_tag = cur_tag; end
      if (wr_en && addr < 8 && model_may(int'(addr))) m_cfg[addr] = wr_data;
      for (int i = 0; i < 4; i++) begin
        if (wr_en && addr == 8'h10 + i) m_tmr[i] = (wr_data == slot_key(i)) ? WIN : 0;
        else if (m_tmr[i] > 0) m_tmr[i] = m_tmr[i] - 1;
      end
      if (wr_en && addr == 8'h18) m_k0 = wr_data;
      if (wr_en && addr == 8'h19) m_k1 = wr_data;
    end
  end

  always @(negedge clk) begin
    if (pend) begin
      checks++;
      if (rd_data !== exp_rd) begin
        bad++;
        $display("FAIL %s: rd_data=%h expected=%h", pend_tag, rd_data, exp_rd);
      end
      pend = 0;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string t);
    cur_tag = t; wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input logic [7:0] a, input string t);
    cur_tag = t; rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask
  task automatic wrrd(input logic [7:0] a, input logic [31:0] d, input string t);
    cur_tag = t; rd_en = 1; wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); rd_en = 0; wr_en = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int j = 0; j < 8; j++) rd(8'(j), "R1");
    for (int i = 0; i < 4; i++) rd(8'h10 + 8'(i), "R1");
    rd(8'h18, "R1"); rd(8'h19, "R1");
    // R2 free words
    wr(6, 32'hCAFE_0006, "R2"); wr(7, 32'hBEEF_0007, "R2");
    rd(6, "R2"); rd(7, "R2");
    // R3 locked drop
    wr(0, 32'h1111_1111, "R3"); rd(0, "R3"); rd(8'h10, "R7");
    // R4 open and window edges
    wr(8'h10, slot_key(0), "R4"); rd(8'h10, "R7"); wr(0, 32'hA0A0_0000, "R4");
    rd(0, "R4"); rd(0, "R7");
    wr(8'h11, slot_key(1), "R4"); idle(WIN - 1); wr(1, 32'hB1B1_0001, "R4"); rd(1, "R4");
    wr(8'h12, slot_key(2), "R4"); idle(WIN); wr(2, 32'hC2C2_0002, "R4"); rd(2, "R4");
    rd(8'h12, "R7");
    // R5 wrong key
    wr(8'h13, 32'h0000_BAD0, "R5"); wr(3, 32'hD3D3_0003, "R5"); rd(3, "R5");
    wr(8'h13, slot_key(3), "R5"); wr(8'h13, 32'h0000_BAD0, "R5");
    wr(3, 32'hD3D3_0004, "R5"); rd(3, "R5"); rd(8'h13, "R5");
    // R6 zero relock
    wr(8'h10, slot_key(0), "R6"); wr(8'h10, 32'h0, "R6");
    wr(0, 32'hEEEE_0000, "R6"); rd(0, "R6"); rd(8'h10, "R6");
    // R11 slot keys are distinct
    wr(8'h10, slot_key(1), "R11"); wr(0, 32'h1234_0000, "R11"); rd(0, "R11");
    wr(8'h11, slot_key(0), "R11"); wr(1, 32'h1234_0001, "R11"); rd(1, "R11");
    // R8 kick pair
    wr(8'h18, K0, "R8"); wr(4, 32'h4444_0001, "R8"); rd(4, "R8");
    rd(8'h18, "R8"); rd(8'h19, "R8");
    wr(8'h19, K1, "R8"); wr(4, 32'h4444_0002, "R8"); wr(5, 32'h5555_0002, "R8");
    rd(4, "R8"); rd(5, "R8"); rd(8'h19, "R8");
    // R3 open kick does not open lock-guarded word
    wr(0, 32'h0BAD_0000, "R3"); rd(0, "R3");
    // R9 clearing either kick
    wr(8'h18, 32'h0, "R9"); wr(4, 32'h4444_0003, "R9"); rd(4, "R9");
    wr(8'h18, K0, "R9"); wr(5, 32'h5555_0004, "R9"); rd(5, "R9");
    wr(8'h19, 32'h0, "R9"); wr(5, 32'h5555_0005, "R9"); rd(5, "R9");
    // R10 read-during-write, unmapped
    wrrd(6, 32'h6666_6666, "R10"); rd(6, "R10");
    wr(8'h30, 32'hFFFF_FFFF, "R10"); rd(8'h30, "R10"); rd(8'h1A, "R10");
    rd(7, "R10");
    idle(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule